// File: doc/BRIEF.md
# Posted-CAS Data-Window Timing Generator

This block is the data-path timing engine of a double-data-rate memory controller. Column commands (reads and writes) arrive on a valid/ready stream after arbitration has already chosen them. A command may be posted early: its burst is held back internally by the programmed additive latency, then by the CAS latency. For every accepted command the block raises a one-cycle start strobe and a data-valid window in the clock cycles in which the burst occupies the shared data bus. A read appears at read latency (additive plus CAS). A write appears one cycle sooner, so write latency is always read latency minus one.

The CAS latency, additive latency and burst length live in a small shadow of the mode registers, loaded through a plain write port. Data moves on both clock edges, so a burst of N transfers fills N/2 clock cycles. Up to several commands are tracked at once in shift-register schedules that are deep enough for the longest latency plus the longest burst.

Back-pressure follows one rule. `cmd_ready` is a function only of the schedule and of the direction offered on `cmd_wr`. It never depends on `cmd_valid`. It is low exactly when the offered command's window would overlap a cycle that is already booked. A command is taken on a rising edge where both `cmd_valid` and `cmd_ready` are high. The producer must hold the command until it is accepted. Windows that touch end to end are allowed, so bursts can run with no gap.

Top module: `ptg_top`

## Requirements
- R1: After reset, `rd_start`, `rd_window`, `wr_start`, `wr_window` and `cfg_err` are low and `cmd_ready` is high. The settings are CAS latency 3, additive latency 0 and burst length 4.
- R2: A read accepted on edge E makes `rd_start` high for one cycle, in the cycle after edge E+AL+CL. `rd_window` is high from that same cycle for BL/2 consecutive cycles.
- R3: A write accepted on edge E makes `wr_start` high in the cycle after edge E+AL+CL-1. `wr_window` is high for BL/2 cycles from that cycle.
- R4: Burst length is written as the value 4 or 8 at `cfg_addr` 2. It gives windows of 2 or 4 cycles respectively.
- R5: Settings are selected by `cfg_addr`. The codes are 0 for CAS latency (legal 3..7), 1 for additive latency (legal 0..6) and 2 for burst length. A legal write leaves `cfg_err` low and applies to commands accepted after that edge.
- R6: A write of an out-of-range value, or any write to `cfg_addr` 3, is ignored. `cfg_err` is high for exactly the one cycle after that edge.
- R7: A settings write is ignored, and `cfg_err` pulses, while any command is in flight or when a command is accepted on the same edge. In-flight means its window has not yet ended.
- R8: `cmd_ready` is low exactly when the offered command's window would overlap a booked cycle of either direction. `rd_window` and `wr_window` are never high together, and windows may abut with no gap.
- R9: Several commands may be outstanding at once, and each produces its own start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Settings write strobe |
| cfg_addr | input | 2 | Settings select: 0 CAS, 1 additive, 2 burst length |
| cfg_wdata | input | CFG_DW | Settings value |
| cfg_err | output | 1 | One-cycle pulse: rejected settings write |
| cmd_valid | input | 1 | Column command offered |
| cmd_ready | output | 1 | Offered command fits the schedule |
| cmd_wr | input | 1 | 1 = write, 0 = read |
| rd_start | output | 1 | First cycle of a read burst |
| rd_window | output | 1 | Read data due on the bus |
| wr_start | output | 1 | First cycle of a write burst |
| wr_window | output | 1 | Write data due on the bus |

## Verification
Start strobes are due AL+CL registered edges after the accept edge for a read, and one edge fewer for a write. Windows last BL/2 cycles from there. `cfg_err` is due one edge after the settings write. `cmd_ready` is combinational on the state after the last edge. The bench sweeps every legal CL, AL and burst length for both directions, counts edges from the accept edge and samples at the falling edge. It compares the first strobe cycle and the window length with AL+CL(-1) and BL/2, computed arithmetically. Error, lock-out and back-pressure cases are driven as fixed edge-by-edge sequences whose expected values per falling edge are worked out from the same formulas.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
  // settings select codes on the write port
  typedef enum logic [1:0] {
    SEL_CAS   = 2'd0,
    SEL_ADD   = 2'd1,
    SEL_BURST = 2'd2,
    SEL_RSV   = 2'd3
  } ptg_sel_e;
endpackage

// File: rtl/ptg_mode_shadow.sv
module ptg_mode_shadow
  import ptg_pkg::*;
#(
  parameter int CFG_DW = 4,
  parameter int MIN_CL = 3,
  parameter int MAX_CL = 7,
  parameter int MAX_AL = 6,
  parameter int MIN_BL = 4,
  parameter int MAX_BL = 8,
  localparam int CLW = $clog2(MAX_CL + 1),
  localparam int ALW = $clog2(MAX_AL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [CFG_DW-1:0] wdata,
  input  logic              lock,
  output logic [CLW-1:0]    cas_q,
  output logic [ALW-1:0]    add_q,
  output logic              long_q,
  output logic              err_q
);
  localparam logic [CFG_DW-1:0] CL_LO = CFG_DW'(MIN_CL);
  localparam logic [CFG_DW-1:0] CL_HI = CFG_DW'(MAX_CL);
  localparam logic [CFG_DW-1:0] AL_HI = CFG_DW'(MAX_AL);
  localparam logic [CFG_DW-1:0] BL_S  = CFG_DW'(MIN_BL);
  localparam logic [CFG_DW-1:0] BL_L  = CFG_DW'(MAX_BL);

  logic legal;
  logic apply;

  always_comb begin
    unique case (ptg_sel_e'(sel))
      SEL_CAS:   legal = (wdata >= CL_LO) && (wdata <= CL_HI);
      SEL_ADD:   legal = (wdata <= AL_HI);
      SEL_BURST: legal = (wdata == BL_S) || (wdata == BL_L);
      default:   legal = 1'b0;
    endcase
  end

  assign apply = we && legal && !lock;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cas_q  <= CLW'(MIN_CL);
      add_q  <= '0;
      long_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q <= we && !apply;
      if (apply) begin
        unique case (ptg_sel_e'(sel))
          SEL_CAS:   cas_q  <= CLW'(wdata);
          SEL_ADD:   add_q  <= ALW'(wdata);
          SEL_BURST: long_q <= (wdata == BL_L);
          default:   ;
        endcase
      end
    end
  end

  AST_LOCK_HOLDS_SETTINGS: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(cas_q) && $stable(add_q) && $stable(long_q)); // R7
  AST_LOCKED_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && lock) |=> err_q); // R7
  AST_CAS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_q >= CLW'(MIN_CL)) && (cas_q <= CLW'(MAX_CL))); // R6
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> !err_q); // R6
endmodule

// File: rtl/ptg_lat_mask.sv
module ptg_lat_mask #(
  parameter int D   = 17,
  parameter int CLW = 3,
  parameter int ALW = 3,
  parameter int MIN_BL = 4,
  parameter int MAX_BL = 8,
  localparam int IW = $clog2(D + 1)
) (
  input  logic [CLW-1:0] cas,
  input  logic [ALW-1:0] add,
  input  logic           long_burst,
  input  logic           is_wr,
  output logic [D-1:0]   start_mask,
  output logic [D-1:0]   win_mask
);
  logic [IW-1:0] lat;
  logic [IW-1:0] beats;
  logic [IW-1:0] lat_end;

  // write latency is one cycle below read latency
  assign lat     = IW'(add) + IW'(cas) - IW'(is_wr);
  assign beats   = long_burst ? IW'(MAX_BL / 2) : IW'(MIN_BL / 2);
  assign lat_end = lat + beats;

  for (genvar i = 0; i < D; i++) begin : g_slot
    assign start_mask[i] = (lat == IW'(i));
    assign win_mask[i]   = (IW'(i) >= lat) && (IW'(i) < lat_end);
  end
endmodule

// File: rtl/ptg_sched.sv
module ptg_sched #(
  parameter int D = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [D-1:0] start_mask,
  input  logic [D-1:0] win_mask,
  output logic         start_o,
  output logic         win_o,
  output logic [D-1:0] occ_q
);
  logic [D-1:0] strt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strt_q <= '0;
      occ_q  <= '0;
    end else begin
      strt_q <= (strt_q >> 1) | (load ? start_mask : '0);
      occ_q  <= (occ_q  >> 1) | (load ? win_mask   : '0);
    end
  end

  assign start_o = strt_q[0];
  assign win_o   = occ_q[0];

  AST_START_INSIDE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> win_o); // R2
  AST_WINDOW_OPENS_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_o) |-> start_o); // R9
endmodule

// File: rtl/ptg_top.sv
module ptg_top
  import ptg_pkg::*;
#(
  parameter int CFG_DW = 4,
  parameter int MIN_CL = 3,
  parameter int MAX_CL = 7,
  parameter int MAX_AL = 6,
  parameter int MIN_BL = 4,
  parameter int MAX_BL = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic              cfg_err,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_wr,
  output logic              rd_start,
  output logic              rd_window,
  output logic              wr_start,
  output logic              wr_window
);
  localparam int D   = MAX_CL + MAX_AL + MAX_BL / 2;
  localparam int CLW = $clog2(MAX_CL + 1);
  localparam int ALW = $clog2(MAX_AL + 1);
  localparam int NCH = 2; // channel 0 read, 1 write

  logic [CLW-1:0] cas;
  logic [ALW-1:0] add;
  logic           long_burst;
  logic [D-1:0]   start_mask, win_mask;
  logic [NCH-1:0] load, ch_start, ch_win;
  logic [NCH-1:0][D-1:0] occ;
  logic [D-1:0]   booked;
  logic           accept, lock;

  ptg_mode_shadow #(
    .CFG_DW(CFG_DW), .MIN_CL(MIN_CL), .MAX_CL(MAX_CL),
    .MAX_AL(MAX_AL), .MIN_BL(MIN_BL), .MAX_BL(MAX_BL)
  ) u_mode (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_addr), .wdata(cfg_wdata),
    .lock(lock), .cas_q(cas), .add_q(add), .long_q(long_burst), .err_q(cfg_err)
  );

  ptg_lat_mask #(
    .D(D), .CLW(CLW), .ALW(ALW), .MIN_BL(MIN_BL), .MAX_BL(MAX_BL)
  ) u_mask (
    .cas(cas), .add(add), .long_burst(long_burst), .is_wr(cmd_wr),
    .start_mask(start_mask), .win_mask(win_mask)
  );

  assign booked    = occ[0] | occ[1];
  assign cmd_ready = ~|((booked >> 1) & win_mask);
  assign accept    = cmd_valid && cmd_ready;
  assign load[0]   = accept && !cmd_wr;
  assign load[1]   = accept && cmd_wr;
  assign lock      = (|booked) || accept;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ptg_sched #(.D(D)) u_sched (
      .clk(clk), .rst_n(rst_n), .load(load[c]),
      .start_mask(start_mask), .win_mask(win_mask),
      .start_o(ch_start[c]), .win_o(ch_win[c]), .occ_q(occ[c])
    );
  end

  assign rd_start  = ch_start[0];
  assign rd_window = ch_win[0];
  assign wr_start  = ch_start[1];
  assign wr_window = ch_win[1];

  AST_BUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_window && wr_window)); // R8
  AST_STARTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_start, wr_start})); // R8
  AST_WR_WINDOW_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_window) |-> wr_start); // R3
endmodule

// File: tb/sim_ptg_top.sv
`timescale 1ns/1ps
module sim_ptg_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [3:0] cfg_wdata = 4'd0;
  logic cfg_err, cmd_ready, rd_start, rd_window, wr_start, wr_window;
  logic cmd_valid = 1'b0;
  logic cmd_wr = 1'b0;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  ptg_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_err(cfg_err), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_wr(cmd_wr), .rd_start(rd_start),
    .rd_window(rd_window), .wr_start(wr_start), .wr_window(wr_window)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // returns cfg_err seen in the cycle after the write edge
  task automatic cfg_write(input logic [1:0] a, input logic [3:0] d, output logic e);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    e = cfg_err;
  endtask

  // one command from idle; edges counted from the accept edge
  task automatic run_cmd(input logic wr, output int first_start, output int nstart,
                         output int first_win, output int nwin);
    logic s, w;
    first_start = -1; first_win = -1; nstart = 0; nwin = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_wr = wr;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 0; k < 24; k++) begin
      if (k > 0) @(negedge clk);
      s = wr ? wr_start : rd_start;
      w = wr ? wr_window : rd_window;
      if (s) begin nstart++; if (first_start < 0) first_start = k; end
      if (w) begin nwin++; if (first_win < 0) first_win = k; end
    end
    cmd_wr = 1'b0;
  endtask

  initial begin
    logic e;
    int fs, ns, fw, nw;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({rd_start, rd_window, wr_start, wr_window, cfg_err} == 5'b0, "R1 outputs low after reset",
        {rd_start, rd_window, wr_start, wr_window, cfg_err}, 0);
    chk(cmd_ready == 1'b1, "R1 ready after reset", cmd_ready, 1);
    run_cmd(1'b0, fs, ns, fw, nw);
    chk(fs == 3 && nw == 2, "R1 default read latency 3 (start)", fs, 3);

    // exhaustive sweep of legal settings, both directions
    for (int cl = 3; cl <= 7; cl++) begin
      for (int al = 0; al <= 6; al++) begin
        for (int b = 0; b < 2; b++) begin
          int bl;
          int ebad;
          bl = b ? 8 : 4;
          ebad = 0;
          cfg_write(2'd0, 4'(cl), e); ebad += int'(e);
          cfg_write(2'd1, 4'(al), e); ebad += int'(e);
          cfg_write(2'd2, 4'(bl), e); ebad += int'(e);
          chk(ebad == 0, $sformatf("R5 legal writes cl=%0d al=%0d bl=%0d no error", cl, al, bl), ebad, 0);
          for (int d = 0; d < 2; d++) begin
            int lat;
            lat = al + cl - d;
            run_cmd(d[0], fs, ns, fw, nw);
            chk(fs == lat && fw == lat && ns == 1,
                $sformatf("%s start cl=%0d al=%0d", d ? "R3 write" : "R2 read", cl, al), fs, lat);
            chk(nw == bl / 2,
                $sformatf("R4 %s window length bl=%0d", d ? "write" : "read", bl), nw, bl / 2);
          end
        end
      end
    end

    // R6 illegal values rejected
    cfg_write(2'd0, 4'd4, e);
    cfg_write(2'd1, 4'd1, e);
    cfg_write(2'd2, 4'd4, e);
    cfg_write(2'd0, 4'd2, e);  chk(e == 1'b1, "R6 CL=2 flagged", e, 1);
    @(negedge clk);            chk(cfg_err == 1'b0, "R6 error lasts one cycle", cfg_err, 0);
    cfg_write(2'd0, 4'd8, e);  chk(e == 1'b1, "R6 CL=8 flagged", e, 1);
    cfg_write(2'd1, 4'd7, e);  chk(e == 1'b1, "R6 AL=7 flagged", e, 1);
    cfg_write(2'd2, 4'd5, e);  chk(e == 1'b1, "R6 BL=5 flagged", e, 1);
    cfg_write(2'd3, 4'd4, e);  chk(e == 1'b1, "R6 select 3 flagged", e, 1);
    run_cmd(1'b0, fs, ns, fw, nw);
    chk(fs == 5 && nw == 2, "R6 settings unchanged after rejected writes", fs, 5);

    // R7 write while in flight
    @(negedge clk);
    cmd_valid = 1'b1; cmd_wr = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    cfg_write(2'd0, 4'd7, e);
    chk(e == 1'b1, "R7 write during flight flagged", e, 1);
    repeat (20) @(negedge clk);
    run_cmd(1'b0, fs, ns, fw, nw);
    chk(fs == 5, "R7 in-flight write ignored", fs, 5);
    // R7 same-edge accept and write
    @(negedge clk);
    cmd_valid = 1'b1; cmd_wr = 1'b0;
    cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 4'd7;
    @(negedge clk);
    cmd_valid = 1'b0; cfg_we = 1'b0;
    chk(cfg_err == 1'b1, "R7 same-edge write flagged", cfg_err, 1);
    repeat (20) @(negedge clk);
    run_cmd(1'b0, fs, ns, fw, nw);
    chk(fs == 5, "R7 same-edge write ignored", fs, 5);

    // R8/R9 back-pressure and gapless reads, CL3 AL0 BL4
    cfg_write(2'd0, 4'd3, e);
    cfg_write(2'd1, 4'd0, e);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_wr = 1'b0;
    @(posedge clk);
    @(negedge clk);                       // after E0
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, "R8 overlapping read refused", cmd_ready, 0);
    @(negedge clk);                       // after E1
    chk(cmd_ready == 1'b1, "R8 abutting read allowed", cmd_ready, 1);
    cmd_valid = 1'b1;
    @(negedge clk);                       // after E2
    cmd_valid = 1'b0;
    for (int k = 3; k <= 7; k++) begin
      @(negedge clk);
      chk(rd_window == (k <= 6), $sformatf("R8 gapless read window k=%0d", k), rd_window, int'(k <= 6));
      chk(rd_start == (k == 3 || k == 5), $sformatf("R9 per-command strobe k=%0d", k), rd_start,
          int'(k == 3 || k == 5));
    end

    // R8 write after read
    repeat (20) @(negedge clk);
    cmd_valid = 1'b1; cmd_wr = 1'b0;
    @(posedge clk);
    @(negedge clk);                       // after E0
    cmd_valid = 1'b0; cmd_wr = 1'b1;
    chk(cmd_ready == 1'b0, "R8 write refused after E0", cmd_ready, 0);
    @(negedge clk);
    chk(cmd_ready == 1'b0, "R8 write refused after E1", cmd_ready, 0);
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R8 write allowed after E2", cmd_ready, 1);
    cmd_valid = 1'b1;
    @(negedge clk);                       // after E3
    cmd_valid = 1'b0; cmd_wr = 1'b0;
    chk(rd_window == 1'b1 && wr_window == 1'b0, "R8 read owns bus k=3", rd_window, 1);
    @(negedge clk);
    chk(rd_window == 1'b1 && wr_window == 1'b0, "R8 read owns bus k=4", rd_window, 1);
    @(negedge clk);
    chk(wr_window == 1'b1 && wr_start == 1'b1 && rd_window == 1'b0, "R8 write follows k=5", wr_window, 1);
    @(negedge clk);
    chk(wr_window == 1'b1 && rd_window == 1'b0, "R8 write k=6", wr_window, 1);

    repeat (5) @(negedge clk);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule